// File: doc/BRIEF.md
# Two-Wire Serial Byte Register Core

This block is the data and status register core of a two-wire serial peripheral. A single byte register serves both directions of the bus. While a byte is on the wire, every bit strobe from an external bit-timing unit shifts the register left by one place. The sampled serial data bit enters at the bottom, and the top bit drives the serial output, so the most significant bit goes first. Because the outgoing byte and the incoming byte share one register, the register holds the last byte that was on the bus once eight bits have passed.

After the eighth strobe the block raises its interrupt flag and stops shifting. While the flag is high the byte register is frozen and accepts a CPU write, which loads the next byte to send. Software restarts shifting by writing a one to the flag bit. A status register carries a five-bit code supplied by an external protocol controller, a reserved bit that always reads zero, and a two-bit clock prescaler select that the CPU can read and write. The decoded division factor is given on an output port for the bit-timing unit. An interrupt request is raised while the flag, the local enable and the global enable are all set.

The sequencing is a two-state machine. In `ST_SHIFT` the flag is low and strobes shift bits while a 3-bit counter counts them. The transition `SHIFT_TO_HOLD` happens on the strobe that completes a byte. In `ST_HOLD` the flag is high, strobes are ignored and the data register accepts CPU writes. The transition `HOLD_TO_SHIFT` happens on a CPU write with a one in the flag bit, and it clears the bit counter. Reset enters `ST_SHIFT`.

Top module: `twb_core`

## Requirements
- R1: After reset the data register reads 0xFF, the status register reads 0xF8, the control register reads 0x00, the serial output is 1, the interrupt request is 0 and the division output is 1.
- R2: Status register (address 1) bit 2 always reads 0. Bits 1:0 are the prescaler select and can be read and written. A CPU write never changes bits 7:3.
- R3: The division output equals 1, 4, 16 or 64 for prescaler select 00, 01, 10 or 11.
- R4: Status bits 7:3 show the value of the `status_code` input, registered one clock after it is applied.
- R5: In `ST_SHIFT` each bit strobe shifts the data register (address 0) left by one and loads `sda_in` into bit 0. `sda_out` always equals data bit 7.
- R6: The eighth strobe after reset or after a flag clear sets the flag, which is control register (address 2) bit 7. The data register then holds the eight sampled bits, with the first sample in bit 7.
- R7: While the flag is set, bit strobes have no effect and the data register is unchanged except by CPU data writes.
- R8: A CPU write to the data register while the flag is clear is ignored.
- R9: A CPU write to the data register while the flag is set loads the written byte.
- R10: Writing control bit 7 as 1 while the flag is set clears the flag, and the next eight strobes form a new byte. Writing bit 7 as 0 leaves the flag unchanged. Control bit 0 is a read/write interrupt enable.
- R11: `irq` is 1 exactly when the flag, the interrupt enable and `global_ie` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| bit_strobe | input | 1 | One-cycle pulse per bus bit from the bit-timing unit |
| sda_in | input | 1 | Sampled serial data bit |
| sda_out | output | 1 | Serial data to drive, data register bit 7 |
| status_code | input | 5 | Status code from the protocol controller |
| global_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| presc_div | output | 7 | Decoded prescaler division factor |

## Verification
Every register write, strobe and status-code change takes effect at the first rising edge after it is driven. That covers the data register, the flag, the prescaler select and the registered status code. `rd_data`, `sda_out`, `irq` and `presc_div` are decoded combinationally from those registers, so each result is due in the same cycle the register changes. The bench drives inputs on falling edges and releases them after one rising edge. It then queues the expected value of each output and selects the register being read. A monitor compares the queued values five nanoseconds after the following falling edge, well clear of any rising edge. The reference byte is tracked in the bench by applying the shift rule bit by bit.

// File: rtl/twb_pkg.sv
package twb_pkg;
    localparam int DATA_W = 8;
    localparam int CODE_W = 5;
    localparam int PSEL_W = 2;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2
    } addr_e;

    typedef enum logic {
        ST_SHIFT = 1'b0,
        ST_HOLD  = 1'b1
    } state_e;
endpackage

// File: rtl/twb_fsm.sv
module twb_fsm
    import twb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic clr_req,
    output logic flag,
    output logic shift_en
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    state_e         st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SHIFT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: SHIFT_TO_HOLD on the byte's last strobe, HOLD_TO_SHIFT on clear
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_SHIFT: begin
                if (strobe) begin
                    if (cnt_q == LAST) begin
                        cnt_d = '0;
                        st_d  = ST_HOLD;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (clr_req) begin
                    cnt_d = '0;
                    st_d  = ST_SHIFT;
                end
            end
            default: begin
                st_d  = ST_SHIFT;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag     = 1'b0;
        shift_en = 1'b0;
        unique case (st_q)
            ST_SHIFT: shift_en = strobe;
            ST_HOLD:  flag     = 1'b1;
            default:  flag     = 1'b0;
        endcase
    end
endmodule

// File: rtl/twb_shifter.sv
module twb_shifter
    import twb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          load_en,
    input  logic [DW-1:0] load_data,
    input  logic          sda_in,
    output logic [DW-1:0] data,
    output logic          sda_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '1;
        end else if (shift_en) begin
            data <= {data[DW-2:0], sda_in};
        end else if (load_en) begin
            data <= load_data;
        end
    end

    assign sda_out = data[DW-1];
endmodule

// File: rtl/twb_regs.sv
module twb_regs
    import twb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CODE_W,
    parameter int PW = PSEL_W,
    localparam int DIV_W = 2 * ((1 << PW) - 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_psel,
    input  logic             wr_ie,
    input  logic             wr_clr,
    input  logic             flag,
    input  logic [DW-1:0]    data,
    input  logic [CW-1:0]    code_in,
    output logic             data_we,
    output logic             clr_req,
    output logic             ie,
    output logic [DIV_W-1:0] div,
    output logic [DW-1:0]    rd_data
);
    localparam int NSEL = 1 << PW;

    logic [CW-1:0]    code_q;
    logic [PW-1:0]    psel_q;
    logic [DIV_W-1:0] div_tab [NSEL];

    assign data_we = wr_en && (addr == A_DATA) && flag;
    assign clr_req = wr_en && (addr == A_CTRL) && wr_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '1;
            psel_q <= '0;
            ie     <= 1'b0;
        end else begin
            code_q <= code_in;
            if (wr_en && addr == A_STAT) psel_q <= wr_psel;
            if (wr_en && addr == A_CTRL) ie     <= wr_ie;
        end
    end

    // each select step multiplies the division by four
    for (genvar g = 0; g < NSEL; g++) begin : g_div
        assign div_tab[g] = DIV_W'(1) << (2 * g);
    end
    assign div = div_tab[psel_q];

    always_comb begin
        case (addr)
            A_DATA:  rd_data = data;
            A_STAT:  rd_data = {code_q, 1'b0, psel_q};
            A_CTRL:  rd_data = {flag, {(DW-2){1'b0}}, ie};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/twb_core.sv
module twb_core
    import twb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CODE_W,
    parameter int PW = PSEL_W,
    localparam int DIV_W = 2 * ((1 << PW) - 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic             bit_strobe,
    input  logic             sda_in,
    output logic             sda_out,
    input  logic [CW-1:0]    status_code,
    input  logic             global_ie,
    output logic             irq,
    output logic [DIV_W-1:0] presc_div
);
    logic          flag;
    logic          shift_en;
    logic          data_we;
    logic          clr_req;
    logic          ie;
    logic [DW-1:0] data_q;

    twb_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_strobe),
        .clr_req  (clr_req),
        .flag     (flag),
        .shift_en (shift_en)
    );

    twb_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .load_en   (data_we),
        .load_data (wr_data),
        .sda_in    (sda_in),
        .data      (data_q),
        .sda_out   (sda_out)
    );

    twb_regs #(.DW(DW), .CW(CW), .PW(PW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_psel (wr_data[PW-1:0]),
        .wr_ie   (wr_data[0]),
        .wr_clr  (wr_data[DW-1]),
        .flag    (flag),
        .data    (data_q),
        .code_in (status_code),
        .data_we (data_we),
        .clr_req (clr_req),
        .ie      (ie),
        .div     (presc_div),
        .rd_data (rd_data)
    );

    assign irq = flag & ie & global_ie;
endmodule

// File: rtl/twb_core_chk.sv
module twb_core_chk
    import twb_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    addr,
    input logic          wr_en,
    input logic          bit_strobe,
    input logic          global_ie,
    input logic          flag,
    input logic [DW-1:0] data,
    input logic          sda_out,
    input logic          irq,
    input logic [DW-1:0] rd_data
);
    logic data_wr;
    assign data_wr = wr_en && (addr == A_DATA);

    assert_bit2_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_STAT) |-> (rd_data[2] == 1'b0));

    assert_shift_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_strobe && !flag) |=> (sda_out == $past(data[DW-2])));

    assert_flag_from_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(bit_strobe));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !data_wr) |=> $stable(data));

    assert_ignore_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !bit_strobe && data_wr) |=> $stable(data));

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && global_ie));
endmodule

bind twb_core twb_core_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .bit_strobe (bit_strobe),
    .global_ie  (global_ie),
    .flag       (flag),
    .data       (data_q),
    .sda_out    (sda_out),
    .irq        (irq),
    .rd_data    (rd_data)
);

// File: tb/twb_core_test.sv
`timescale 1ns/1ps
module twb_core_test;
    localparam int K_RD   = 0;
    localparam int K_SDA  = 1;
    localparam int K_IRQ  = 2;
    localparam int K_DIV  = 3;

    typedef struct {
        int         req;
        int         kind;
        logic [7:0] val;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       bit_strobe = 1'b0;
    logic       sda_in = 1'b0;
    logic       sda_out;
    logic [4:0] status_code = 5'h1F;
    logic       global_ie = 1'b0;
    logic       irq;
    logic [6:0] presc_div;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb [$];
    logic [7:0] model;

    always #10 clk = ~clk;

    twb_core uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .bit_strobe  (bit_strobe),
        .sda_in      (sda_in),
        .sda_out     (sda_out),
        .status_code (status_code),
        .global_ie   (global_ie),
        .irq         (irq),
        .presc_div   (presc_div)
    );

    // monitor: compares queued items 5 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                exp_t  e;
                logic [7:0] act;
                e = sb.pop_front();
                case (e.kind)
                    K_SDA:   act = {7'b0, sda_out};
                    K_IRQ:   act = {7'b0, irq};
                    K_DIV:   act = {1'b0, presc_div};
                    default: act = rd_data;
                endcase
                n_checks++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL R%0d kind %0d: actual %h expected %h", e.req, e.kind, act, e.val);
                end
            end
        end
    end

    task automatic push(input int req, input int kind, input logic [7:0] val);
        exp_t e;
        e.req = req; e.kind = kind; e.val = val;
        sb.push_back(e);
    endtask

    // caller is at a falling edge; selects register and queues expectation
    task automatic chk_rd(input int req, input logic [1:0] a, input logic [7:0] val);
        addr = a;
        push(req, K_RD, val);
        #6;
        @(negedge clk);
    endtask

    task automatic chk_out(input int req, input int kind, input logic [7:0] val);
        push(req, kind, val);
        #6;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic b);
        sda_in = b; bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    // shifts a byte MSB first, checking each step of the shift and the flag
    task automatic shift_byte(input logic [7:0] byte_in);
        for (int i = 7; i >= 0; i--) begin
            strobe(byte_in[i]);
            model = {model[6:0], byte_in[i]};
            chk_out(5, K_SDA, {7'b0, model[7]});          // R5
            if (i > 0) begin
                chk_rd(5, 2'd0, model);                   // R5
                chk_rd(6, 2'd2, {1'b0, 6'b0, 1'b0} | {7'b0, cur_ie});
            end
        end
        chk_rd(6, 2'd0, byte_in);                         // R6
        chk_rd(6, 2'd2, {1'b1, 6'b0, cur_ie});            // R6
    endtask

    logic cur_ie = 1'b0;

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk_rd(1, 2'd0, 8'hFF);
        chk_rd(1, 2'd1, 8'hF8);
        chk_rd(1, 2'd2, 8'h00);
        chk_out(1, K_SDA, 8'h01);
        chk_out(1, K_IRQ, 8'h00);
        chk_out(1, K_DIV, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        chk_rd(1, 2'd1, 8'hF8);

        // R2: code field not writable, bit 2 zero, select read/write
        wr(2'd1, 8'h07);
        chk_rd(2, 2'd1, 8'hFB);
        wr(2'd1, 8'h00);
        chk_rd(2, 2'd1, 8'hF8);

        // R3: division decode
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, 8'(s));
            chk_out(3, K_DIV, 8'(1 << (2 * s)));
            chk_rd(3, 2'd1, 8'hF8 | 8'(s));
        end
        wr(2'd1, 8'h00);

        // R4: status code follows input
        status_code = 5'h0A;
        @(negedge clk);
        chk_rd(4, 2'd1, 8'h50);
        status_code = 5'h15;
        @(negedge clk);
        chk_rd(4, 2'd1, 8'hA8);

        // R8: data write while flag clear ignored
        wr(2'd0, 8'h3C);
        chk_rd(8, 2'd0, 8'hFF);

        // R5 / R6: first byte
        shift_byte(8'hA5);

        // R11: interrupt gating
        chk_out(11, K_IRQ, 8'h00);
        wr(2'd2, 8'h01);
        cur_ie = 1'b1;
        chk_rd(10, 2'd2, 8'h81);                          // R10 bit7=0 keeps flag
        chk_out(11, K_IRQ, 8'h00);
        global_ie = 1'b1;
        @(negedge clk);
        chk_out(11, K_IRQ, 8'h01);

        // R7: strobes ignored while flag set
        strobe(1'b0);
        strobe(1'b0);
        chk_rd(7, 2'd0, 8'hA5);
        chk_out(7, K_SDA, 8'h01);

        // R9: data write while flag set
        wr(2'd0, 8'h5A);
        model = 8'h5A;
        chk_rd(9, 2'd0, 8'h5A);
        chk_out(9, K_SDA, 8'h00);

        // R10: clearing the flag restarts a byte
        wr(2'd2, 8'h81);
        chk_rd(10, 2'd2, 8'h01);
        chk_out(11, K_IRQ, 8'h00);
        chk_rd(10, 2'd0, 8'h5A);
        wr(2'd0, 8'h77);                                  // R8 again
        chk_rd(8, 2'd0, 8'h5A);
        shift_byte(8'h0F);                                // R10 new byte of eight
        chk_out(11, K_IRQ, 8'h01);
        wr(2'd2, 8'h00);
        cur_ie = 1'b0;
        chk_rd(10, 2'd2, 8'h80);
        chk_out(11, K_IRQ, 8'h00);

        done = 1'b1;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule